// File: doc/BRIEF.md
# Power-up clock mode selector

This block settles the operating mode of a clock generator when power comes up. It runs a power-on window timer and tracks the two frequency-select straps while that window is open. One strap shares its pin with the reference clock output. When the window closes, the block freezes the strap values and hands that shared pin over to the reference output. A separate control pin starts out meaning "outputs off / test". After the window it can take on the meaning "power down", and once it has done so it keeps that meaning until the next reset.

From the frozen straps and the current pin role, the block produces a mode code and a divide ratio for each clock group. There is also a flag that selects the overdriven test clock as the divider source, a global high-impedance enable, and the pin-role flag. A power-down request is produced while the pin acts as power-down and is held low. Normal-mode ratios are stated against a 400 MHz main oscillator for the CPU, SDRAM, 66 MHz and 33 MHz groups, a 96 MHz oscillator for the 48 MHz group, and the crystal for the reference. Clock synthesis itself is done elsewhere.

Top module: `clk_mode_sel`

## Requirements
- R1: While reset is held, and right after it is released, `mode_o` is 3'b000, `hiz_o` is 1, and `ref_oe_o`, `pd_role_o` and `pd_req_o` are 0.
- R2: `ref_oe_o` is 0 for the first WIN_CYC-1 clock edges after reset release and may be 1 from edge WIN_CYC onward. The strap values seen before edge WIN_CYC are kept, and any strap change after that edge has no effect on `mode_o`.
- R3: When the control pin has the outputs-off role, the pin is low and latched FSEL0 is 0, `mode_o` is 3'b000. In this state `hiz_o` is 1, `ref_oe_o` and `test_src_o` are 0, and all six divide outputs are 0, whatever FSEL1 is.
- R4: In the outputs-off role with the pin low and latched FSEL0 = 1, `mode_o` is 3'b001 and `test_src_o` is 1. The divide ratios of the test clock are CPU 4, SDRAM 4, 66 MHz group 6, PCI/APIC 12, 48 MHz group 2 and reference 1.
- R5: When the pin is high, or has the power-down role, `mode_o` is {1, FSEL1, FSEL0}. The CPU/SDRAM ratios are 6/4 for 00, 4/4 for 01, 3/3 for 10 and 3/4 for 11. The 66 MHz group uses 6, PCI/APIC 12, the 48 MHz group 2 and the reference 1, with `test_src_o` = 0 and `hiz_o` = 0.
- R6: If the synchronized pin is high on any edge from the window's end onward, `pd_role_o` is 1 one edge later.
- R7: If the pin stays low past the window's end, `pd_role_o` stays 0 and the pin keeps its outputs-off/test meaning.
- R8: `cfg_pd_role_i` = 1 on a clock edge sets `pd_role_o` from that edge on, even inside the window.
- R9: Once `pd_role_o` is 1, it stays 1 until reset, whatever the pin or `cfg_pd_role_i` do.
- R10: `pd_req_o` is 1 exactly when `pd_role_o` is 1 and the synchronized pin is low. In the power-down role `mode_o` stays in the normal set (bit 2 = 1).
- R11: The control pin and both straps pass through SYNC_STAGES flops. A change on the pin shows on `mode_o` exactly SYNC_STAGES edges after it is applied.

Bench runs use WIN_CYC = 40 and SYNC_STAGES = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| fsel0_i | input | 1 | Frequency select strap, low bit |
| fsel1_strap_i | input | 1 | Shared strap/reference pin value, high select bit |
| ctl_pin_i | input | 1 | Dual-role control pin (outputs-off/test, later power-down), asynchronous |
| cfg_pd_role_i | input | 1 | Configuration bit forcing the power-down role |
| mode_o | output | 3 | Mode code: 000 outputs off, 001 test, 1ff normal with straps ff |
| cpu_div_o | output | 4 | CPU group divide ratio |
| sdram_div_o | output | 4 | SDRAM group divide ratio |
| g66_div_o | output | 4 | 66 MHz group divide ratio |
| pci_div_o | output | 4 | PCI and APIC divide ratio |
| g48_div_o | output | 4 | 48 MHz group divide ratio |
| ref_div_o | output | 4 | Reference output divide ratio |
| test_src_o | output | 1 | Dividers take the overdriven test clock |
| hiz_o | output | 1 | All clock outputs high impedance |
| ref_oe_o | output | 1 | Shared strap pin driven as reference output |
| pd_role_o | output | 1 | Control pin acts as power-down |
| pd_req_o | output | 1 | Power-down requested |

## Verification
The bench targets the edge on which the window closes. A timer off by one would enable the reference driver a cycle early or late, or would latch a strap value applied just after the window. A pin that goes high only after the window must still flip the role, and a role that could fall back would reopen the outputs-off state when the pin later goes low. A decoder with swapped CPU/SDRAM entries for 10 and 11, or a missing synchronizer stage, would put the wrong ratio or mode on the outputs for one or more compared cycles.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  localparam int unsigned DIV_W = 4;

  typedef enum logic [2:0] {
    MODE_HIZ      = 3'b000,
    MODE_TEST     = 3'b001,
    MODE_N66_100  = 3'b100,
    MODE_N100_100 = 3'b101,
    MODE_N133_133 = 3'b110,
    MODE_N133_100 = 3'b111
  } mode_e;

  typedef struct packed {
    logic [DIV_W-1:0] cpu;
    logic [DIV_W-1:0] sdr;
    logic [DIV_W-1:0] g66;
    logic [DIV_W-1:0] pci;
    logic [DIV_W-1:0] g48;
    logic [DIV_W-1:0] rfc;
  } div_set_t;

  // normal ratios: 400 MHz main osc, 96 MHz osc for 48 group, crystal for ref
  localparam logic [DIV_W-1:0] DV_66  = DIV_W'(6);
  localparam logic [DIV_W-1:0] DV_100 = DIV_W'(4);
  localparam logic [DIV_W-1:0] DV_133 = DIV_W'(3);
  localparam logic [DIV_W-1:0] DV_33  = DIV_W'(12);
  localparam logic [DIV_W-1:0] DV_48  = DIV_W'(2);
  localparam logic [DIV_W-1:0] DV_REF = DIV_W'(1);

  // test ratios against the overdriven test clock
  localparam logic [DIV_W-1:0] TV_CPU = DIV_W'(4);
  localparam logic [DIV_W-1:0] TV_66  = DIV_W'(6);
  localparam logic [DIV_W-1:0] TV_33  = DIV_W'(12);
  localparam logic [DIV_W-1:0] TV_48  = DIV_W'(2);
  localparam logic [DIV_W-1:0] TV_REF = DIV_W'(1);

endpackage

// File: rtl/cms_sync.sv
module cms_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[g] <= '0;
        else         st[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[g] <= '0;
        else         st[g] <= st[g-1];
      end
    end
  end

  assign q_o = st[STAGES-1];

endmodule

// File: rtl/cms_por_timer.sv
module cms_por_timer #(
  parameter int unsigned WIN_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_done_o
);

  localparam int unsigned CW = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign win_done_o = done_q;

endmodule

// File: rtl/cms_strap_latch.sv
module cms_strap_latch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       win_done_i,
  input  logic [1:0] strap_s_i,
  output logic [1:0] fsel_q_o
);

  // straps track the pins until the window closes, then freeze
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fsel_q_o <= 2'b00;
    else if (!win_done_i) fsel_q_o <= strap_s_i;
  end

endmodule

// File: rtl/cms_role_ctrl.sv
module cms_role_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_done_i,
  input  logic ctl_s_i,
  input  logic cfg_pd_i,
  output logic pd_role_o
);

  logic set_pd;

  assign set_pd = (win_done_i & ctl_s_i) | cfg_pd_i;

  // sticky until power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pd_role_o <= 1'b0;
    else if (set_pd) pd_role_o <= 1'b1;
  end

endmodule

// File: rtl/cms_mode_dec.sv
module cms_mode_dec
  import clk_mode_pkg::*;
(
  input  logic       win_done_i,
  input  logic       pd_role_i,
  input  logic       ctl_s_i,
  input  logic [1:0] fsel_q_i,
  output mode_e      mode_o,
  output div_set_t   div_o,
  output logic       test_src_o,
  output logic       hiz_o,
  output logic       ref_oe_o,
  output logic       pd_req_o
);

  logic tri_n;

  assign tri_n = pd_role_i | ctl_s_i;

  always_comb begin
    if (!tri_n) mode_o = fsel_q_i[0] ? MODE_TEST : MODE_HIZ;
    else        mode_o = mode_e'({1'b1, fsel_q_i});
  end

  always_comb begin
    div_o = '0;
    unique case (mode_o)
      MODE_TEST: begin
        div_o.cpu = TV_CPU; div_o.sdr = TV_CPU; div_o.g66 = TV_66;
        div_o.pci = TV_33;  div_o.g48 = TV_48;  div_o.rfc = TV_REF;
      end
      MODE_N66_100, MODE_N100_100, MODE_N133_133, MODE_N133_100: begin
        div_o.g66 = DV_66; div_o.pci = DV_33; div_o.g48 = DV_48; div_o.rfc = DV_REF;
        unique case (fsel_q_i)
          2'b00:   begin div_o.cpu = DV_66;  div_o.sdr = DV_100; end
          2'b01:   begin div_o.cpu = DV_100; div_o.sdr = DV_100; end
          2'b10:   begin div_o.cpu = DV_133; div_o.sdr = DV_133; end
          default: begin div_o.cpu = DV_133; div_o.sdr = DV_100; end
        endcase
      end
      default: div_o = '0;
    endcase
  end

  assign test_src_o = (mode_o == MODE_TEST);
  assign hiz_o      = (mode_o == MODE_HIZ);
  assign ref_oe_o   = win_done_i & (mode_o != MODE_HIZ);
  assign pd_req_o   = pd_role_i & ~ctl_s_i;

endmodule

// File: rtl/clk_mode_sel.sv
module clk_mode_sel
  import clk_mode_pkg::*;
#(
  parameter int unsigned WIN_CYC     = 500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsel0_i,
  input  logic             fsel1_strap_i,
  input  logic             ctl_pin_i,
  input  logic             cfg_pd_role_i,
  output logic [2:0]       mode_o,
  output logic [DIV_W-1:0] cpu_div_o,
  output logic [DIV_W-1:0] sdram_div_o,
  output logic [DIV_W-1:0] g66_div_o,
  output logic [DIV_W-1:0] pci_div_o,
  output logic [DIV_W-1:0] g48_div_o,
  output logic [DIV_W-1:0] ref_div_o,
  output logic             test_src_o,
  output logic             hiz_o,
  output logic             ref_oe_o,
  output logic             pd_role_o,
  output logic             pd_req_o
);

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] pins_s;
  logic             ctl_s;
  logic [1:0]       strap_s;
  logic             win_done;
  logic [1:0]       fsel_q;
  logic             pd_role;
  mode_e            mode;
  div_set_t         divs;

  cms_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fsel1_strap_i, fsel0_i, ctl_pin_i}),
    .q_o    (pins_s)
  );

  assign ctl_s   = pins_s[0];
  assign strap_s = pins_s[2:1];

  cms_por_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_done_o (win_done)
  );

  cms_strap_latch u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_done_i (win_done),
    .strap_s_i  (strap_s),
    .fsel_q_o   (fsel_q)
  );

  cms_role_ctrl u_role (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_done_i (win_done),
    .ctl_s_i    (ctl_s),
    .cfg_pd_i   (cfg_pd_role_i),
    .pd_role_o  (pd_role)
  );

  cms_mode_dec u_dec (
    .win_done_i (win_done),
    .pd_role_i  (pd_role),
    .ctl_s_i    (ctl_s),
    .fsel_q_i   (fsel_q),
    .mode_o     (mode),
    .div_o      (divs),
    .test_src_o (test_src_o),
    .hiz_o      (hiz_o),
    .ref_oe_o   (ref_oe_o),
    .pd_req_o   (pd_req_o)
  );

  assign mode_o      = mode;
  assign cpu_div_o   = divs.cpu;
  assign sdram_div_o = divs.sdr;
  assign g66_div_o   = divs.g66;
  assign pci_div_o   = divs.pci;
  assign g48_div_o   = divs.g48;
  assign ref_div_o   = divs.rfc;
  assign pd_role_o   = pd_role;

endmodule

// File: rtl/cms_checker.sv
module cms_checker
  import clk_mode_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_pd_role_i,
  input logic [2:0]       mode_o,
  input logic [DIV_W-1:0] cpu_div_o,
  input logic [DIV_W-1:0] sdram_div_o,
  input logic [DIV_W-1:0] g66_div_o,
  input logic [DIV_W-1:0] pci_div_o,
  input logic [DIV_W-1:0] g48_div_o,
  input logic [DIV_W-1:0] ref_div_o,
  input logic             test_src_o,
  input logic             hiz_o,
  input logic             ref_oe_o,
  input logic             pd_role_o,
  input logic             pd_req_o,
  input logic             win_done_i,
  input logic [1:0]       fsel_q_i
);

  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> (cpu_div_o == '0 && sdram_div_o == '0 && g66_div_o == '0 && pci_div_o == '0
               && g48_div_o == '0 && ref_div_o == '0 && !ref_oe_o && !test_src_o)); // R3

  AST_TEST_RATIOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_src_o |-> (cpu_div_o == 4 && sdram_div_o == 4 && g66_div_o == 6 && pci_div_o == 12
                    && g48_div_o == 2 && ref_div_o == 1)); // R4

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done_i |=> $stable(fsel_q_i)); // R2

  AST_REF_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_oe_o |-> win_done_i); // R2

  AST_ROLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_role_o |=> pd_role_o); // R9

  AST_ROLE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_role_o |-> mode_o[2]); // R10

  AST_PDREQ_ROLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_o |-> pd_role_o); // R10

  AST_CFG_ROLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_pd_role_i |=> pd_role_o); // R8

  AST_ROLE_AFTER_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pd_role_o) && !$past(cfg_pd_role_i)) |-> $past(win_done_i)); // R6

  AST_NORMAL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[2] |-> (!test_src_o && !hiz_o)); // R5

endmodule

bind clk_mode_sel cms_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_pd_role_i (cfg_pd_role_i),
  .mode_o        (mode_o),
  .cpu_div_o     (cpu_div_o),
  .sdram_div_o   (sdram_div_o),
  .g66_div_o     (g66_div_o),
  .pci_div_o     (pci_div_o),
  .g48_div_o     (g48_div_o),
  .ref_div_o     (ref_div_o),
  .test_src_o    (test_src_o),
  .hiz_o         (hiz_o),
  .ref_oe_o      (ref_oe_o),
  .pd_role_o     (pd_role_o),
  .pd_req_o      (pd_req_o),
  .win_done_i    (win_done),
  .fsel_q_i      (fsel_q)
);

// File: tb/sim_clk_mode_sel.sv
module sim_clk_mode_sel;

  localparam int WIN  = 40;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fsel0 = 1'b0, fsel1 = 1'b0, ctl = 1'b0, cfg = 1'b0;
  logic [2:0] mode;
  logic [3:0] cpu_d, sdr_d, g66_d, pci_d, g48_d, ref_d;
  logic test_src, hiz, ref_oe, pd_role, pd_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  clk_mode_sel #(.WIN_CYC(WIN), .SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fsel0_i(fsel0), .fsel1_strap_i(fsel1),
    .ctl_pin_i(ctl), .cfg_pd_role_i(cfg), .mode_o(mode),
    .cpu_div_o(cpu_d), .sdram_div_o(sdr_d), .g66_div_o(g66_d), .pci_div_o(pci_d),
    .g48_div_o(g48_d), .ref_div_o(ref_d), .test_src_o(test_src), .hiz_o(hiz),
    .ref_oe_o(ref_oe), .pd_role_o(pd_role), .pd_req_o(pd_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_edges;
  bit  m_fq[2];
  bit  m_role;
  bit  q_ctl[$], q_f0[$], q_f1[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_edges = 0; m_fq[0] = 0; m_fq[1] = 0; m_role = 0;
      q_ctl = {}; q_f0 = {}; q_f1 = {};
      for (int i = 0; i < SYNC; i++) begin
        q_ctl.push_back(1'b0); q_f0.push_back(1'b0); q_f1.push_back(1'b0);
      end
    end else begin
      bit win_old;
      win_old = (m_edges >= WIN);
      m_role = m_role | (win_old & q_ctl[0]) | cfg;
      if (!win_old) begin m_fq[0] = q_f0[0]; m_fq[1] = q_f1[0]; end
      m_edges++;
      q_ctl.push_back(ctl); void'(q_ctl.pop_front());
      q_f0.push_back(fsel0); void'(q_f0.pop_front());
      q_f1.push_back(fsel1); void'(q_f1.pop_front());
    end
  end

  function automatic int mhz_div(input int osc, input int f);
    return osc / f;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      int emode, sel, ecpu, esdr;
      string tg;
      sel = m_fq[1] * 2 + m_fq[0];
      if (!m_role && !q_ctl[0]) emode = m_fq[0] ? 1 : 0;
      else                      emode = 4 + sel;
      tg = (emode == 0) ? "R3" : (emode == 1) ? "R4" : "R5";
      chk(tg, mode, emode);
      if (emode == 0) begin
        chk("R3", cpu_d, 0); chk("R3", sdr_d, 0); chk("R3", g66_d, 0);
        chk("R3", pci_d, 0); chk("R3", g48_d, 0); chk("R3", ref_d, 0);
      end else if (emode == 1) begin
        chk("R4", cpu_d, 4); chk("R4", sdr_d, 4); chk("R4", g66_d, 6);
        chk("R4", pci_d, 12); chk("R4", g48_d, 2); chk("R4", ref_d, 1);
      end else begin
        ecpu = (sel == 0) ? 66 : (sel == 1) ? 100 : 133;
        esdr = (sel == 2) ? 133 : 100;
        chk("R5", cpu_d, mhz_div(400, ecpu)); chk("R5", sdr_d, mhz_div(400, esdr));
        chk("R5", g66_d, mhz_div(400, 66));   chk("R5", pci_d, mhz_div(400, 33));
        chk("R5", g48_d, mhz_div(96, 48));    chk("R5", ref_d, 1);
      end
      chk(tg, test_src, emode == 1);
      chk(tg, hiz, emode == 0);
      chk("R2", ref_oe, (m_edges >= WIN) && emode != 0);
      chk("R6", pd_role, m_role);
      chk("R10", pd_req, m_role && !q_ctl[0]);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit f1, input bit f0, input bit c);
    #1; fsel1 = f1; fsel0 = f0; ctl = c;
  endtask

  task automatic do_reset(input bit f1, input bit f0, input bit c);
    @(negedge clk); #1;
    rst_ni = 1'b0; cfg = 1'b0; fsel1 = f1; fsel0 = f0; ctl = c;
    @(negedge clk);
    // R1: reset state
    chk("R1", mode, 0); chk("R1", hiz, 1); chk("R1", ref_oe, 0);
    chk("R1", pd_role, 0); chk("R1", pd_req, 0);
    wait_cyc(2);
    #1; rst_ni = 1'b1;
  endtask

  // watchdog
  initial begin
    wait (cyc > 20000);
    n_fail++;
    $display("FAIL R1 watchdog: cycles=%0d expected<=%0d", cyc, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Phase A: test mode at power-up, pin low past the window
    do_reset(1'b1, 1'b1, 1'b0);
    for (int k = 1; k <= WIN + 2; k++) begin
      @(negedge clk);
      chk("R2", ref_oe, k >= WIN);
      chk("R1", pd_role, 0);
    end
    chk("R4", mode, 1);
    drive(1'b0, 1'b0, 1'b0);
    wait_cyc(5);
    chk("R2", mode, 1);        // late strap change ignored
    chk("R7", pd_role, 0);     // pin low: tristate role kept
    drive(1'b0, 1'b0, 1'b1);
    @(negedge clk); chk("R11", mode, 1);
    @(negedge clk); chk("R11", mode, 7); chk("R6", pd_role, 0);
    @(negedge clk); chk("R6", pd_role, 1);
    drive(1'b0, 1'b0, 1'b0);
    wait_cyc(2);
    chk("R10", pd_req, 1); chk("R10", mode, 7); chk("R9", pd_role, 1);
    wait_cyc(10);
    chk("R9", pd_role, 1); chk("R9", hiz, 0);

    // Phase B: outputs off, then config bit forces power-down role
    do_reset(1'b1, 1'b0, 1'b0);
    wait_cyc(WIN + 3);
    chk("R3", hiz, 1); chk("R3", ref_oe, 0); chk("R3", cpu_d, 0); chk("R3", mode, 0);
    #1; cfg = 1'b1;
    @(negedge clk); chk("R8", pd_role, 1); chk("R8", mode, 6);
    #1; cfg = 1'b0;
    wait_cyc(5);
    chk("R9", pd_role, 1); chk("R10", pd_req, 1);

    // Phase C: pin high through power-up, 133/133
    do_reset(1'b1, 1'b0, 1'b1);
    wait_cyc(3);
    chk("R5", mode, 6); chk("R5", cpu_d, 3); chk("R5", sdram_d_chk(), 3);
    wait_cyc(WIN);
    chk("R6", pd_role, 1);
    drive(1'b0, 1'b1, 1'b1);
    wait_cyc(4);
    chk("R2", mode, 6);
    drive(1'b0, 1'b1, 1'b0);
    wait_cyc(3);
    chk("R10", pd_req, 1); chk("R10", mode, 6);

    // Phase D: 100/100, one-cycle pin glitch inside the window
    do_reset(1'b0, 1'b1, 1'b1);
    wait_cyc(5);
    chk("R5", mode, 5); chk("R5", cpu_d, 4);
    drive(1'b0, 1'b1, 1'b0);
    @(negedge clk); #1; ctl = 1'b1;
    @(negedge clk); chk("R11", mode, 1); chk("R4", test_src, 1);
    @(negedge clk); chk("R11", mode, 5);
    wait_cyc(WIN);
    chk("R6", pd_role, 1);

    // Phase E: 66/100
    do_reset(1'b0, 1'b0, 1'b1);
    wait_cyc(WIN + 3);
    chk("R5", mode, 4); chk("R5", cpu_d, 6); chk("R5", sdr_d, 4); chk("R2", ref_oe, 1);

    // Phase F: 133/100
    do_reset(1'b1, 1'b1, 1'b1);
    wait_cyc(WIN + 3);
    chk("R5", mode, 7); chk("R5", cpu_d, 3); chk("R5", sdr_d, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic int sdram_d_chk();
    return int'(sdr_d);
  endfunction

endmodule